// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-ported memory. It watches the enables and word addresses of a left and a right port. When both ports are enabled and point at the same word, it raises a busy flag toward exactly one of them. The port that gets the flag is the one whose inputs settled later. The arbiter also takes each port's active-low write strobe and passes it on gated: a port that is flagged busy cannot write, and the write is dropped without any stall. The memory array itself is not part of the block.

Arrival order is decided per clock cycle. Each port's decoded enable and full address are sampled every cycle. A port "arrives" in any cycle where it is enabled and either was not enabled in the previous cycle or shows a different address. If both ports arrive in the same cycle, a fixed tie-break lets the left port win. While neither port moves, the earlier decision holds. The flags are combinational from the present inputs plus that one-cycle history, so a flag falls in the same cycle the collision ends.

A mode input selects master or slave behaviour. In master mode the block drives its busy outputs push-pull and gates writes with its own decision. In slave mode the busy outputs are held low, and busy flags from a master elsewhere come in on two inputs. Those inputs are used only to block writes.

Top module: `collisionArbiter`

## Requirements
- R1: A port counts as enabled only when its active-low enable is 0 and its active-high enable is 1. Any other combination leaves that port out of collision detection.
- R2: In master mode, both busy outputs are 0 whenever either port is disabled or the low CMP_W address bits differ.
- R3: In master mode, on a match where exactly one port arrived in the present cycle, the busy output of that later port is 1 and the other is 0.
- R4: When both ports arrive at a matching address in the same cycle, including the first cycle after reset with both already enabled, the left port wins: right busy is 1 and left busy is 0.
- R5: The two busy outputs are never 1 at the same time.
- R6: In master mode, the gated write output (active low) of a busy port is 1 regardless of its write input. A non-busy port's gated write equals its write input.
- R7: In slave mode both busy outputs are 0. Each gated write is forced to 1 only while that port's busy input is 1; the block's own collision detection has no effect on writes.
- R8: Only address bits [CMP_W-1:0] (default 18 of 19) are compared. Addresses differing only in bit 18 collide.
- R9: While the match persists and neither port moves, the busy assignment holds. It falls to 0 in the same cycle the match ends.
- R10: While reset is asserted, the history marks both ports as not enabled. With both ports disabled, both busy outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = master (drive busy), 0 = slave (accept busy) |
| leftEnN | input | 1 | Left active-low enable |
| leftEn | input | 1 | Left active-high enable |
| leftAddr | input | ADDR_W | Left word address |
| leftWrN | input | 1 | Left write strobe, active low |
| rightEnN | input | 1 | Right active-low enable |
| rightEn | input | 1 | Right active-high enable |
| rightAddr | input | ADDR_W | Right word address |
| rightWrN | input | 1 | Right write strobe, active low |
| leftBusyIn | input | 1 | Slave mode: external busy for left port |
| rightBusyIn | input | 1 | Slave mode: external busy for right port |
| leftBusyOut | output | 1 | Master mode: left port lost the collision |
| rightBusyOut | output | 1 | Master mode: right port lost the collision |
| leftWrGateN | output | 1 | Gated left write strobe, active low |
| rightWrGateN | output | 1 | Gated right write strobe, active low |

## Verification
The assertions take for granted that the port inputs are steady for a whole clock period. They must change only between active edges, so that the sampled history matches what the combinational flags saw. The bench therefore changes inputs only on the falling edge and samples the outputs shortly after that, well before the next rising edge. Each vector is held for exactly one clock cycle, and the mode input changes only between vectors.

// File: rtl/arbPkg.sv
package arbPkg;
  typedef enum logic {LEFT_WINS = 1'b0, RIGHT_WINS = 1'b1} winnerT;

  // datapath -> control: what happened on the ports this cycle
  typedef struct packed {
    logic match;
    logic leftMoved;
    logic rightMoved;
  } senseT;

  // control -> datapath: the arbitration decision
  typedef struct packed {
    logic leftBusy;
    logic rightBusy;
  } strobeT;
endpackage

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  senseT  sense,
  output strobeT strobes
);
  winnerT winnerQ;
  winnerT winnerNow;

  always_comb begin
    winnerNow = winnerQ;
    if (sense.match) begin
      unique case ({sense.leftMoved, sense.rightMoved})
        2'b10:   winnerNow = RIGHT_WINS;  // left arrived later
        2'b01:   winnerNow = LEFT_WINS;   // right arrived later
        2'b11:   winnerNow = LEFT_WINS;   // same-cycle tie
        default: winnerNow = winnerQ;     // nobody moved: hold
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winnerQ <= LEFT_WINS;
    else       winnerQ <= winnerNow;
  end

  assign strobes.leftBusy  = sense.match && (winnerNow == RIGHT_WINS);
  assign strobes.rightBusy = sense.match && (winnerNow == LEFT_WINS);

  assert_busy_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.leftBusy && strobes.rightBusy));

  assert_idle_without_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sense.match |-> (!strobes.leftBusy && !strobes.rightBusy));

  assert_tie_left_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sense.match && sense.leftMoved && sense.rightMoved) |-> strobes.rightBusy);

  assert_hold_when_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sense.match && !sense.leftMoved && !sense.rightMoved)
      |-> (strobes.leftBusy == $past(strobes.leftBusy)));

  assert_late_port_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sense.match && sense.leftMoved && !sense.rightMoved) |-> strobes.leftBusy);
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CMP_W  = 18,
  parameter int PORTS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic [PORTS-1:0]  enN,
  input  logic [PORTS-1:0]  en,
  input  logic [ADDR_W-1:0] addr [PORTS],
  input  logic [PORTS-1:0]  wrN,
  input  logic [PORTS-1:0]  busyIn,
  input  strobeT            strobes,
  output senseT             sense,
  output logic [PORTS-1:0]  busyOut,
  output logic [PORTS-1:0]  wrGateN
);
  logic [PORTS-1:0]  portOn;
  logic [PORTS-1:0]  prevOn;
  logic [PORTS-1:0]  moved;
  logic [ADDR_W-1:0] prevAddr [PORTS];
  logic [CMP_W-1:0]  cmpAddr  [PORTS];
  logic [PORTS-1:0]  ownBusy;
  logic [PORTS-1:0]  block;

  assign ownBusy = {strobes.rightBusy, strobes.leftBusy};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign portOn[p]  = !enN[p] && en[p];
    assign cmpAddr[p] = addr[p][CMP_W-1:0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevOn[p]   <= 1'b0;
        prevAddr[p] <= '0;
      end else begin
        prevOn[p]   <= portOn[p];
        prevAddr[p] <= addr[p];
      end
    end

    // a port arrives when it becomes enabled or any address pin changes
    assign moved[p]   = portOn[p] && (!prevOn[p] || (prevAddr[p] != addr[p]));
    assign block[p]   = masterMode ? ownBusy[p] : busyIn[p];
    assign busyOut[p] = masterMode && ownBusy[p];
    assign wrGateN[p] = wrN[p] || block[p];
  end

  assign sense.match      = portOn[0] && portOn[1] && (cmpAddr[0] == cmpAddr[1]);
  assign sense.leftMoved  = moved[0];
  assign sense.rightMoved = moved[1];

  assert_busy_write_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && busyOut[0]) |-> wrGateN[0]);

  assert_slave_outputs_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (busyOut == '0));

  assert_disabled_no_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!portOn[0] || !portOn[1]) |-> (busyOut == '0));
endmodule

// File: rtl/collisionArbiter.sv
module collisionArbiter
  import arbPkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CMP_W  = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftEnN,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWrN,
  input  logic              rightEnN,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWrN,
  input  logic              leftBusyIn,
  input  logic              rightBusyIn,
  output logic              leftBusyOut,
  output logic              rightBusyOut,
  output logic              leftWrGateN,
  output logic              rightWrGateN
);
  localparam int PORTS = 2;

  senseT             sense;
  strobeT            strobes;
  logic [ADDR_W-1:0] addrArr [PORTS];
  logic [PORTS-1:0]  busyOutVec;
  logic [PORTS-1:0]  wrGateVec;

  assign addrArr[0] = leftAddr;
  assign addrArr[1] = rightAddr;

  arbDatapath #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .PORTS(PORTS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .masterMode (masterMode),
    .enN        ({rightEnN, leftEnN}),
    .en         ({rightEn, leftEn}),
    .addr       (addrArr),
    .wrN        ({rightWrN, leftWrN}),
    .busyIn     ({rightBusyIn, leftBusyIn}),
    .strobes    (strobes),
    .sense      (sense),
    .busyOut    (busyOutVec),
    .wrGateN    (wrGateVec)
  );

  arbControl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .sense   (sense),
    .strobes (strobes)
  );

  assign leftBusyOut  = busyOutVec[0];
  assign rightBusyOut = busyOutVec[1];
  assign leftWrGateN  = wrGateVec[0];
  assign rightWrGateN = wrGateVec[1];
endmodule

// File: tb/sim_collisionArbiter.sv
module sim_collisionArbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode, leftEnN, leftEn, leftWrN, rightEnN, rightEn, rightWrN;
  logic leftBusyIn, rightBusyIn;
  logic [18:0] leftAddr, rightAddr;
  logic leftBusyOut, rightBusyOut, leftWrGateN, rightWrGateN;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  collisionArbiter u0 (.*);

  typedef struct packed {
    logic        m;
    logic        lEnN, lEn;
    logic [18:0] lA;
    logic        lWr;
    logic        rEnN, rEn;
    logic [18:0] rA;
    logic        rWr;
    logic        lBi, rBi;
    logic        eLB, eRB, eLG, eRG;
    logic [3:0]  req;
  } vecT;

  // fields: m, lEnN,lEn,lA,lWr, rEnN,rEn,rA,rWr, lBi,rBi, expected lBusy,rBusy,lGate,rGate, req
  localparam vecT VEC [17] = '{
    '{1'b1, 1'b1,1'b0,19'h00005,1'b0, 1'b1,1'b0,19'h00005,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 both off
    '{1'b1, 1'b0,1'b1,19'h00005,1'b0, 1'b1,1'b0,19'h00005,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 right off
    '{1'b1, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd3}, // R3 right late
    '{1'b1, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd9}, // R9 hold
    '{1'b1, 1'b0,1'b1,19'h00006,1'b0, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd9}, // R9 drop
    '{1'b1, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd3}, // R3 left late
    '{1'b1, 1'b0,1'b1,19'h00005,1'b0, 1'b1,1'b1,19'h00005,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 enN high
    '{1'b1, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b0,19'h00005,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 en low
    '{1'b1, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b1,19'h00005,1'b0, 1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd3}, // R3 right re-enters
    '{1'b1, 1'b0,1'b1,19'h00100,1'b0, 1'b0,1'b1,19'h00100,1'b0, 1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd4}, // R4 tie
    '{1'b1, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b1,19'h00200,1'b0, 1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd8}, // R8 bit18 ignored
    '{1'b1, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b1,19'h00201,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 differ
    '{1'b1, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd3}, // R3
    '{1'b1, 1'b0,1'b1,19'h40200,1'b1, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b0, 1'b0,1'b1,1'b1,1'b1, 4'd6}, // R6 pass-through
    '{1'b0, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd7}, // R7 slave ignores own
    '{1'b0, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b1,19'h40200,1'b0, 1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0, 4'd7}, // R7 left blocked
    '{1'b0, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b1,19'h40200,1'b0, 1'b0,1'b1, 1'b0,1'b0,1'b0,1'b1, 4'd7}  // R7 right blocked
  };

  task automatic check(input logic [3:0] req, input logic eLB, eRB, eLG, eRG, input string tag);
    logic [3:0] act, exp;
    act = {leftBusyOut, rightBusyOut, leftWrGateN, rightWrGateN};
    exp = {eLB, eRB, eLG, eRG};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: lBusy,rBusy,lGate,rGate actual %b expected %b", req, tag, act, exp);
    end
    checks++;
    if (leftBusyOut && rightBusyOut) begin  // R5 on every sample
      fails++;
      $display("FAIL R5 %s: both busy actual 11 expected not 11", tag);
    end
  endtask

  task automatic drive(input vecT v);
    masterMode = v.m;
    leftEnN = v.lEnN; leftEn = v.lEn; leftAddr = v.lA; leftWrN = v.lWr;
    rightEnN = v.rEnN; rightEn = v.rEn; rightAddr = v.rA; rightWrN = v.rWr;
    leftBusyIn = v.lBi; rightBusyIn = v.rBi;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    drive(VEC[0]);
    // R10: in reset, both disabled -> quiet
    repeat (3) @(negedge clk);
    #1 check(4'd10, 1'b0, 1'b0, 1'b0, 1'b0, "reset state");
    @(negedge clk);
    rstN = 1'b1;
    // table walk: each vector one cycle, checked 1 ns after the falling edge
    foreach (VEC[i]) begin
      @(negedge clk);
      drive(VEC[i]);
      #1 check(VEC[i].req, VEC[i].eLB, VEC[i].eRB, VEC[i].eLG, VEC[i].eRG, $sformatf("vector %0d", i));
    end
    // R4 / R10: both already colliding when reset releases -> tie, left wins
    @(negedge clk);
    rstN = 1'b0;
    masterMode = 1'b1;
    leftEnN = 1'b0; leftEn = 1'b1; leftAddr = 19'h0ABCD; leftWrN = 1'b0;
    rightEnN = 1'b0; rightEn = 1'b1; rightAddr = 19'h0ABCD; rightWrN = 1'b0;
    leftBusyIn = 1'b0; rightBusyIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1 check(4'd4, 1'b0, 1'b1, 1'b0, 1'b1, "first cycle after reset");
    @(negedge clk);
    #1 check(4'd9, 1'b0, 1'b1, 1'b0, 1'b1, "held after reset");
    // R9: winner disabled -> busy falls the same cycle
    @(negedge clk);
    leftEn = 1'b0;
    #1 check(4'd9, 1'b0, 1'b0, 1'b0, 0, "winner disabled");
    // R6: loser write high stays high, winner write passes
    @(negedge clk);
    leftEn = 1'b1;
    #1 check(4'd3, 1'b1, 1'b0, 1'b1, 1'b0, "left re-arrives late");
    @(negedge clk);
    rightWrN = 1'b1;
    #1 check(4'd6, 1'b1, 1'b0, 1'b1, 1'b1, "winner write released");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule